// File: doc/BRIEF.md
# SPI Host Register and FIFO Front End

This block sits between a simple 32-bit memory-mapped bus and a SPI frame engine. It holds the control, frame-setup, interrupt-enable and status registers. It buffers outgoing and incoming bytes in two 16-entry byte FIFOs. Software fills the transmit FIFO and drains the receive FIFO through a byte-wide port or a word-wide port. The engine drains the transmit FIFO and fills the receive FIFO one byte at a time.

A control bit selects four-byte granularity. While it is set, the word ports move four stream bytes per bus transfer, least significant byte first. The empty and full flags then report whether a whole word can be moved. Writing the frame-setup register latches the frame parameters, clears the done flags and, when the engine is idle, raises a one-cycle start pulse. A level interrupt is the OR of the low six status bits, each gated by its enable bit.

Top module: `spih_regif`

## Requirements
- R1: After reset, control, interrupt enable and the frame registers read 0, irq is low, and status (offset 0x10) reads 0x098 while eng_busy is low.
- R2: Control (offset 0x00) stores and reads back only the bits in mask 0x0F01FC0F. Bit 16 is the four-byte mode bit. The stored value drives ctrl_cfg.
- R3: A write to offset 0x44 pushes wdata[7:0] into the transmit FIFO. The engine receives the bytes on eng_tx_byte in push order and pops them with eng_tx_pop.
- R4: A read of offset 0x40 returns the oldest received byte in bits 7:0, with bits 31:8 zero, and pops it. bus_rdata holds the result from the cycle after the access.
- R5: With control bit 16 set, a write to 0x4C pushes four bytes (wdata[7:0] first) and a read of 0x48 pops four bytes (oldest in bits 7:0). With bit 16 clear, a 0x4C write pushes nothing, and a 0x48 read returns 0 and pops nothing.
- R6: Status bit 4 (receive empty) is set while the receive FIFO holds fewer bytes than the granule. Status bit 5 (transmit full) is set while the transmit FIFO has fewer free slots than the granule. The granule is 4 in four-byte mode and 1 otherwise. Bit 2 is the inverse of bit 4, bit 3 is the inverse of bit 5, and bit 8 mirrors control bit 16.
- R7: Each FIFO holds 16 bytes. A push into a FIFO without room for the access is dropped. A pop from a FIFO without enough data is dropped, and a receive read in that case returns 0. The FIFO contents are kept in both cases.
- R8: A write to 0x04 latches frame_cfg. A write to 0x50 latches frame_upper from wdata[15:0]. A write to 0x04 while eng_busy is low gives frame_start high for exactly the next cycle. While eng_busy is high, no start pulse follows.
- R9: An eng_tx_done pulse sets status bit 0 and an eng_rx_done pulse sets status bit 1. Both bits stay set until the next write to 0x04 clears them.
- R10: Interrupt enable (offset 0x0C) stores bits 5:0. irq equals the OR over the low six status bits, each ANDed with its enable bit.
- R11: Status bit 7 (ready) is the inverse of eng_busy.
- R12: Reads of unmapped offsets return 0. Writes to status and to the receive ports change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt |
| ctrl_cfg | output | 32 | Control register contents to the engine |
| frame_cfg | output | 32 | Latched frame-setup word |
| frame_upper | output | 16 | Upper half of the frame byte count |
| frame_start | output | 1 | One-cycle frame start pulse |
| eng_busy | input | 1 | Engine busy with a frame |
| eng_tx_done | input | 1 | Transmit-complete pulse |
| eng_rx_done | input | 1 | Receive-complete pulse |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_byte | output | 8 | Oldest transmit byte |
| eng_tx_empty | output | 1 | Transmit FIFO holds no byte |
| eng_rx_push | input | 1 | Engine delivers one receive byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_full | output | 1 | Receive FIFO has no free slot |

## Verification
A bus access sampled at one rising edge updates register and FIFO state at that edge. Its read data appears on bus_rdata from the same edge, so it is sampled at the falling edge that follows. frame_start is registered and is due in the single cycle after the frame write's edge. irq, eng_tx_byte and the FIFO flags are combinational from state and change at the edge that changed the state. The bench drives every input at a falling edge and samples one half-cycle after the edge it expects the result on. Engine-side pushes and pops likewise finish an edge before the next bus access observes them.

// File: rtl/spih_pkg.sv
package spih_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  // byte offsets of the mapped registers and ports
  localparam logic [31:0] OFF_CTRL  = 32'h00;
  localparam logic [31:0] OFF_FRAME = 32'h04;
  localparam logic [31:0] OFF_IEN   = 32'h0C;
  localparam logic [31:0] OFF_STAT  = 32'h10;
  localparam logic [31:0] OFF_RXB   = 32'h40;
  localparam logic [31:0] OFF_TXB   = 32'h44;
  localparam logic [31:0] OFF_RXW   = 32'h48;
  localparam logic [31:0] OFF_TXW   = 32'h4C;
  localparam logic [31:0] OFF_FUP   = 32'h50;

  // writable control bits: enable, master, direct/xip, clock idle, sample,
  // width modes, four-byte mode, clock rate
  localparam logic [31:0] CTRL_WMASK = 32'h0F01_FC0F;
  localparam int CB_WIDE = 16;

  localparam int IEN_W  = 6;
  localparam int STAT_W = 9;
  localparam int FUP_W  = 16;
endpackage

// File: rtl/spih_fifo.sv
module spih_fifo #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gran_wide,
  input  logic               push_en,
  input  logic               push_wide,
  input  logic [8*LANES-1:0] push_data,
  input  logic               pop_en,
  input  logic               pop_wide,
  output logic [8*LANES-1:0] head_data,
  output logic [CNT_W-1:0]   level,
  output logic               short_data,
  output logic               short_room
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_nxt, rd_q, rd_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, free_c, push_need, pop_need, gran_need;
  logic             push_acc, pop_acc;

  always_comb begin
    push_need = push_wide ? CNT_W'(LANES) : CNT_W'(1);
    pop_need  = pop_wide  ? CNT_W'(LANES) : CNT_W'(1);
    gran_need = gran_wide ? CNT_W'(LANES) : CNT_W'(1);
    free_c    = CNT_W'(DEPTH) - cnt_q;
    push_acc  = push_en && (free_c >= push_need);
    pop_acc   = pop_en && (cnt_q >= pop_need);
    wr_nxt    = push_acc ? wr_q + PTR_W'(push_need) : wr_q;
    rd_nxt    = pop_acc  ? rd_q + PTR_W'(pop_need)  : rd_q;
    cnt_nxt   = cnt_q + (push_acc ? push_need : '0) - (pop_acc ? pop_need : '0);
    short_data = cnt_q < gran_need;
    short_room = free_c < gran_need;
    level      = cnt_q;
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_head
      assign head_data[8*l +: 8] = mem[rd_q + PTR_W'(l)];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_nxt;
      rd_q  <= rd_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (push_acc && (l == 0 || push_wide)) begin
        mem[wr_q + PTR_W'(l)] <= push_data[8*l +: 8];
      end
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && cnt_q == '0 && !push_en) |=> cnt_q == '0);

  // R5
  wide_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && pop_wide && cnt_q >= CNT_W'(LANES) && !push_en)
      |=> cnt_q == $past(cnt_q) - CNT_W'(LANES));

  // R3
  byte_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !push_wide && cnt_q < CNT_W'(DEPTH) && !pop_en)
      |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/spih_status.sv
module spih_status
  import spih_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_set,
  input  logic              rx_set,
  input  logic              done_clr,
  input  logic              rx_short,
  input  logic              tx_short,
  input  logic              busy,
  input  logic              wide,
  input  logic [IEN_W-1:0]  ien,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic txd_q, txd_nxt, rxd_q, rxd_nxt;

  always_comb begin
    txd_nxt = tx_set ? 1'b1 : (done_clr ? 1'b0 : txd_q);
    rxd_nxt = rx_set ? 1'b1 : (done_clr ? 1'b0 : rxd_q);
    status  = {wide, !busy, 1'b0, tx_short, rx_short, !tx_short, !rx_short,
               rxd_q, txd_q};
    irq     = |(status[IEN_W-1:0] & ien);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q <= 1'b0;
      rxd_q <= 1'b0;
    end else begin
      txd_q <= txd_nxt;
      rxd_q <= rxd_nxt;
    end
  end

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !tx_set) |=> !status[0]);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !done_clr) |=> status[1]);
endmodule

// File: rtl/spih_regif.sv
module spih_regif
  import spih_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [31:0]       ctrl_cfg,
  output logic [31:0]       frame_cfg,
  output logic [15:0]       frame_upper,
  output logic              frame_start,
  input  logic              eng_busy,
  input  logic              eng_tx_done,
  input  logic              eng_rx_done,
  input  logic              eng_tx_pop,
  output logic [7:0]        eng_tx_byte,
  output logic              eng_tx_empty,
  input  logic              eng_rx_push,
  input  logic [7:0]        eng_rx_byte,
  output logic              eng_rx_full
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [31:0] off);
    return a[ADDR_W-1:2] == off[ADDR_W-1:2];
  endfunction

  logic                  wr, rd, wide;
  logic                  h_ctrl, h_frm, h_ien, h_stat, h_rxb, h_txb, h_rxw, h_txw, h_fup;
  logic [31:0]           ctrl_q, ctrl_nxt, frm_q, frm_nxt, rdata_q, rdata_nxt;
  logic [FUP_W-1:0]      fup_q, fup_nxt;
  logic [IEN_W-1:0]      ien_q, ien_nxt;
  logic                  start_q, start_nxt;
  logic                  tx_push, rx_pop;
  logic [8*LANES-1:0]    tx_head, rx_head;
  logic [CNT_W-1:0]      tx_level, rx_level;
  logic                  tx_short_data, tx_short_room, rx_short_data, rx_short_room;
  logic [STAT_W-1:0]     status;

  always_comb begin
    wr     = bus_en && bus_we;
    rd     = bus_en && !bus_we;
    wide   = ctrl_q[CB_WIDE];
    h_ctrl = hit(bus_addr, OFF_CTRL);
    h_frm  = hit(bus_addr, OFF_FRAME);
    h_ien  = hit(bus_addr, OFF_IEN);
    h_stat = hit(bus_addr, OFF_STAT);
    h_rxb  = hit(bus_addr, OFF_RXB);
    h_txb  = hit(bus_addr, OFF_TXB);
    h_rxw  = hit(bus_addr, OFF_RXW);
    h_txw  = hit(bus_addr, OFF_TXW);
    h_fup  = hit(bus_addr, OFF_FUP);

    ctrl_nxt  = (wr && h_ctrl) ? (bus_wdata & CTRL_WMASK) : ctrl_q;
    frm_nxt   = (wr && h_frm)  ? bus_wdata : frm_q;
    fup_nxt   = (wr && h_fup)  ? bus_wdata[FUP_W-1:0] : fup_q;
    ien_nxt   = (wr && h_ien)  ? bus_wdata[IEN_W-1:0] : ien_q;
    start_nxt = wr && h_frm && !eng_busy;

    tx_push = wr && (h_txb || (h_txw && wide));
    rx_pop  = rd && (h_rxb || (h_rxw && wide));

    rdata_nxt = '0;
    if (h_ctrl)      rdata_nxt = ctrl_q;
    else if (h_frm)  rdata_nxt = frm_q;
    else if (h_ien)  rdata_nxt = 32'(ien_q);
    else if (h_stat) rdata_nxt = 32'(status);
    else if (h_fup)  rdata_nxt = 32'(fup_q);
    else if (h_rxb)  rdata_nxt = (rx_level != '0) ? 32'(rx_head[7:0]) : '0;
    else if (h_rxw)  rdata_nxt = (wide && rx_level >= CNT_W'(LANES)) ? rx_head : '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q  <= '0;
      frm_q   <= '0;
      fup_q   <= '0;
      ien_q   <= '0;
      start_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_nxt;
      frm_q   <= frm_nxt;
      fup_q   <= fup_nxt;
      ien_q   <= ien_nxt;
      start_q <= start_nxt;
      if (rd) rdata_q <= rdata_nxt;
    end
  end

  spih_fifo #(.DEPTH(FIFO_DEPTH), .LANES(LANES)) u_txq (
    .clk(clk), .rst_n(rst_i_n), .gran_wide(wide),
    .push_en(tx_push), .push_wide(h_txw), .push_data(bus_wdata),
    .pop_en(eng_tx_pop), .pop_wide(1'b0),
    .head_data(tx_head), .level(tx_level),
    .short_data(tx_short_data), .short_room(tx_short_room)
  );

  spih_fifo #(.DEPTH(FIFO_DEPTH), .LANES(LANES)) u_rxq (
    .clk(clk), .rst_n(rst_i_n), .gran_wide(wide),
    .push_en(eng_rx_push), .push_wide(1'b0), .push_data(32'(eng_rx_byte)),
    .pop_en(rx_pop), .pop_wide(h_rxw),
    .head_data(rx_head), .level(rx_level),
    .short_data(rx_short_data), .short_room(rx_short_room)
  );

  spih_status u_stat (
    .clk(clk), .rst_n(rst_i_n),
    .tx_set(eng_tx_done), .rx_set(eng_rx_done), .done_clr(wr && h_frm),
    .rx_short(rx_short_data), .tx_short(tx_short_room),
    .busy(eng_busy), .wide(wide), .ien(ien_q),
    .status(status), .irq(irq)
  );

  assign bus_rdata    = rdata_q;
  assign ctrl_cfg     = ctrl_q;
  assign frame_cfg    = frm_q;
  assign frame_upper  = fup_q;
  assign frame_start  = start_q;
  assign eng_tx_byte  = tx_head[7:0];
  assign eng_tx_empty = tx_level == '0;
  assign eng_rx_full  = rx_level == CNT_W'(FIFO_DEPTH);

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    frame_start |-> $past(!eng_busy));

  // R2
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ctrl_cfg & ~CTRL_WMASK) == '0);

  // R11
  ready_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    status[7] == !eng_busy);
endmodule

// File: tb/spih_regif_test.sv
module spih_regif_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, ctrl_cfg, frame_cfg;
  logic [15:0] frame_upper;
  logic        irq, frame_start, eng_busy, eng_tx_done, eng_rx_done;
  logic        eng_tx_pop, eng_tx_empty, eng_rx_push, eng_rx_full;
  logic [7:0]  eng_tx_byte, eng_rx_byte;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  spih_regif uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .ctrl_cfg(ctrl_cfg), .frame_cfg(frame_cfg),
    .frame_upper(frame_upper), .frame_start(frame_start),
    .eng_busy(eng_busy), .eng_tx_done(eng_tx_done), .eng_rx_done(eng_rx_done),
    .eng_tx_pop(eng_tx_pop), .eng_tx_byte(eng_tx_byte),
    .eng_tx_empty(eng_tx_empty), .eng_rx_push(eng_rx_push),
    .eng_rx_byte(eng_rx_byte), .eng_rx_full(eng_rx_full)
  );

  // {is_read, addr, wdata, expected}
  localparam int NV = 14;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'hFFFF_FFFF, 32'h0},            // R2
    {1'b1, 8'h00, 32'h0,         32'h0F01_FC0F},    // R2
    {1'b0, 8'h00, 32'h0,         32'h0},
    {1'b1, 8'h00, 32'h0,         32'h0},            // R2
    {1'b0, 8'h0C, 32'hFFFF_FFFF, 32'h0},            // R10
    {1'b1, 8'h0C, 32'h0,         32'h0000_003F},    // R10
    {1'b0, 8'h0C, 32'h0,         32'h0},
    {1'b1, 8'h08, 32'h0,         32'h0},            // R12
    {1'b0, 8'h10, 32'hFFFF_FFFF, 32'h0},            // R12
    {1'b1, 8'h10, 32'h0,         32'h0000_0098},    // R12
    {1'b0, 8'h50, 32'hABCD_1234, 32'h0},            // R8
    {1'b1, 8'h50, 32'h0,         32'h0000_1234},    // R8
    {1'b0, 8'h04, 32'h0002_0005, 32'h0},            // R8
    {1'b1, 8'h04, 32'h0,         32'h0002_0005}     // R8
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    r = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r;
    acc(1'b1, a, d, r);
  endtask

  task automatic rdv(input logic [7:0] a, output logic [31:0] r);
    acc(1'b0, a, 32'h0, r);
  endtask

  task automatic eng_put(input logic [7:0] b);
    eng_rx_push = 1'b1; eng_rx_byte = b;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic eng_get(output logic [7:0] b);
    b = eng_tx_byte;
    eng_tx_pop = 1'b1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  b;
    int          n;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    eng_busy = 1'b0; eng_tx_done = 1'b0; eng_rx_done = 1'b0;
    eng_tx_pop = 1'b0; eng_rx_push = 1'b0; eng_rx_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 ctrl_cfg", ctrl_cfg, 0);
    chk("R1 frame_start", 32'(frame_start), 0);
    rdv(8'h10, r); chk("R1 status", r, 32'h98);
    rdv(8'h04, r); chk("R1 frames", r, 0);

    // register table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) begin
        rdv(VEC[i][71:64], r);
        chk($sformatf("R2/R8/R10/R12 vec%0d", i), r, VEC[i][31:0]);
      end else begin
        wr(VEC[i][71:64], VEC[i][63:32]);
      end
    end
    wr(8'h00, 32'h0F00_0003);
    chk("R2 ctrl_cfg", ctrl_cfg, 32'h0F00_0003);
    wr(8'h00, 32'h0);

    // R10 irq masking
    wr(8'h0C, 32'h10); chk("R10 irq rx-empty enabled", 32'(irq), 1);
    wr(8'h0C, 32'h04); chk("R10 irq rx-avail enabled", 32'(irq), 0);
    wr(8'h0C, 32'h0);

    // R3 byte transmit
    wr(8'h44, 32'hA1); wr(8'h44, 32'hB2); wr(8'h44, 32'hFFC3);
    chk("R3 not empty", 32'(eng_tx_empty), 0);
    eng_get(b); chk("R3 byte0", 32'(b), 32'hA1);
    eng_get(b); chk("R3 byte1", 32'(b), 32'hB2);
    eng_get(b); chk("R3 byte2", 32'(b), 32'hC3);
    chk("R3 drained", 32'(eng_tx_empty), 1);

    // R4 byte receive, R7 empty read
    eng_put(8'h5A); eng_put(8'h6B);
    rdv(8'h40, r); chk("R4 rx0", r, 32'h5A);
    rdv(8'h40, r); chk("R4 rx1", r, 32'h6B);
    rdv(8'h40, r); chk("R7 empty read", r, 0);

    // R5 word ports ignored without four-byte mode
    wr(8'h4C, 32'h1122_3344);
    chk("R5 word write ignored", 32'(eng_tx_empty), 1);
    eng_put(8'h01); eng_put(8'h02); eng_put(8'h03); eng_put(8'h04);
    rdv(8'h48, r); chk("R5 word read ignored", r, 0);
    rdv(8'h40, r); chk("R5 no pop", r, 32'h01);
    rdv(8'h40, r); rdv(8'h40, r); rdv(8'h40, r);

    // R5/R6 four-byte mode
    wr(8'h00, 32'h0001_0000);
    rdv(8'h10, r); chk("R6 wide empty status", r, 32'h198);
    wr(8'h4C, 32'h4433_2211);
    eng_get(b); chk("R5 tx lane0", 32'(b), 32'h11);
    eng_get(b); chk("R5 tx lane1", 32'(b), 32'h22);
    eng_get(b); chk("R5 tx lane2", 32'(b), 32'h33);
    eng_get(b); chk("R5 tx lane3", 32'(b), 32'h44);
    for (int i = 1; i <= 7; i++) eng_put(8'(i));
    rdv(8'h10, r); chk("R6 seven held", r & 32'h14, 32'h04);
    rdv(8'h48, r); chk("R5 rx word", r, 32'h0403_0201);
    rdv(8'h10, r); chk("R6 three held wide", r & 32'h14, 32'h10);
    rdv(8'h48, r); chk("R7 short word read", r, 0);
    wr(8'h00, 32'h0);
    rdv(8'h10, r); chk("R6 three held byte", r & 32'h114, 32'h04);
    rdv(8'h40, r); chk("R7 kept 5", r, 32'h05);
    rdv(8'h40, r); chk("R7 kept 6", r, 32'h06);
    rdv(8'h40, r); chk("R7 kept 7", r, 32'h07);

    // R7 transmit overflow
    for (int i = 0; i < 17; i++) wr(8'h44, 32'(i));
    rdv(8'h10, r); chk("R6 tx full", r & 32'h28, 32'h20);
    n = 0;
    while (!eng_tx_empty && n < 40) begin
      eng_get(b); chk("R7 order", 32'(b), 32'(n)); n++;
    end
    chk("R7 depth", 32'(n), 16);

    // R6 transmit full granularity
    for (int i = 0; i < 13; i++) wr(8'h44, 32'(i));
    rdv(8'h10, r); chk("R6 13 byte mode", r & 32'h28, 32'h08);
    wr(8'h00, 32'h0001_0000);
    rdv(8'h10, r); chk("R6 13 wide mode", r & 32'h28, 32'h20);
    wr(8'h4C, 32'hDEAD_BEEF);
    wr(8'h00, 32'h0);
    n = 0;
    while (!eng_tx_empty && n < 40) begin eng_get(b); n++; end
    chk("R7 word push dropped", 32'(n), 13);

    // R8 frame start
    wr(8'h04, 32'h8001_000A);
    chk("R8 start pulse", 32'(frame_start), 1);
    chk("R8 frame_cfg", frame_cfg, 32'h8001_000A);
    @(negedge clk);
    chk("R8 pulse one cycle", 32'(frame_start), 0);
    eng_busy = 1'b1;
    rdv(8'h10, r); chk("R11 not ready", r & 32'h80, 0);
    wr(8'h04, 32'h0000_0001);
    chk("R8 no start when busy", 32'(frame_start), 0);
    eng_busy = 1'b0;
    chk("R8 upper out", 32'(frame_upper), 32'h1234);

    // R9 done flags
    eng_tx_done = 1'b1; @(negedge clk); eng_tx_done = 1'b0;
    eng_rx_done = 1'b1; @(negedge clk); eng_rx_done = 1'b0;
    repeat (2) @(negedge clk);
    rdv(8'h10, r); chk("R9 done set", r & 32'h3, 32'h3);
    wr(8'h0C, 32'h01); chk("R10 irq tx done", 32'(irq), 1);
    wr(8'h04, 32'h0);
    rdv(8'h10, r); chk("R9 done cleared", r & 32'h3, 0);
    chk("R10 irq cleared", 32'(irq), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule